// File: doc/BRIEF.md
# SDRAM Read Command Scheduler

This block sits on the controller side of an SDRAM interface and turns read requests into READ commands aimed at a row that is already open. Each request names a bank, a starting column, a word count, an auto-precharge choice and an identifier, and arrives over a valid/ready handshake. The scheduler drives the chip-select, row-strobe, column-strobe, write-enable, A10, bank and column pins, then picks up the returned data words from the DQ bus after the programmed CAS latency. It hands each word on with the identifier of its request and a flag on the final word.

The device is assumed to be set to a fixed burst length `BL`. A request may want fewer words than that. The scheduler then places the next READ so that it cuts the running burst short just after the last wanted word. Back-to-back requests therefore yield an unbroken stream of words. A request with auto precharge cannot be cut short, so the whole burst is allowed to play out. The unwanted tail of that burst shows up as idle cycles on the output.

A shift register as deep as the longest CAS latency carries a tag for each expected data cycle. Capture is therefore a tap on that pipe, and the data path needs no counter.

Top module: `sdram_rd_sched`

## Requirements
- R1: While reset is held and after it is released with no request pending, the pins show NOP (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1), `rd_valid` and `rd_last` are 0, and `req_ready` is 1.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) puts a READ on the pins for the following cycle (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=0, `sd_we_n`=1), with `sd_ba` equal to `req_bank`, `sd_col` equal to `req_col`, and `sd_a10` equal to `req_ap`.
- R3: In every cycle that does not follow an accepted request, the pins show NOP.
- R4: The first word of a request appears on `rd_valid` exactly CL+1 cycles after its READ first appears on the pins. CL is 2 when `cfg_cl3`=0 and 3 when `cfg_cl3`=1. `cfg_cl3` changes only while no read is in flight.
- R5: A request with `req_len`=n delivers n+1 words, taken from columns `req_col` through `req_col`+n in that order. Every word carries `req_id` on `rd_id`, and `rd_last` is high on the final word only.
- R6: Without auto precharge, a request with `req_len`=n drops `req_ready` for n cycles after acceptance. A request held waiting is therefore accepted so that its READ comes n+1 cycles after the previous READ, and its first word directly follows the previous request's last word with no idle cycle on `rd_valid`.
- R7: With auto precharge, the next READ comes `BL` cycles after the READ of that request. `rd_valid` stays low for `BL`-(n+1) cycles between the two requests' words.
- R8: Single-word requests (`req_len`=0, no auto precharge) are accepted on consecutive cycles. This gives a READ every cycle and one word per cycle on the output.
- R9: DQ values in cycles that carry no tagged word, including the untransferred tail of an auto-precharge burst, never produce `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cl3 | input | 1 | CAS latency select: 0 = 2 cycles, 1 = 3 cycles |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_bank | input | BANK_W | Bank of the request |
| req_col | input | COL_W | Starting column |
| req_len | input | clog2(BL) | Word count minus one |
| req_ap | input | 1 | Auto precharge at the end of the burst |
| req_id | input | ID_W | Tag returned with every word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Auto-precharge pin on a READ |
| sd_ba | output | BANK_W | Bank address |
| sd_col | output | COL_W | Column address |
| sd_dq | input | DQ_W | Read data from the device |
| rd_valid | output | 1 | Captured word present |
| rd_data | output | DQ_W | Captured word |
| rd_id | output | ID_W | Identifier of the word's request |
| rd_last | output | 1 | Final word of its request |

## Verification
The case hardest to reach from the ports is a READ that cuts a running burst short while the old burst's remaining words are still on DQ. It must hit the cycle at which the new data lines up behind the last wanted word. The bench gets there with a device model that fills a table of future data cycles on every READ, so that a later READ overwrites the earlier burst's tail. The bench then streams requests of mixed lengths without dropping `req_valid`, under both CAS latencies. Each returned word is checked for its column, its tag and its cycle, and the stream is checked for gaps. An auto-precharge request followed by a waiting request exposes the burst tail. The bench checks that those DQ cycles stay invisible on `rd_valid`.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t SD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t SD_READ = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};

  localparam int CL_SHORT = 2;
  localparam int CL_LONG  = 3;

endpackage

// File: rtl/sdram_rd_issue.sv
module sdram_rd_issue
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int BL     = 4,
  parameter int ID_W   = 4,
  localparam int LEN_W = $clog2(BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ap,
  input  logic [ID_W-1:0]   req_id,
  output sd_cmd_t           cmd,
  output logic              cmd_a10,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [COL_W-1:0]  cmd_col,
  output logic              slot_v,
  output logic [ID_W-1:0]   slot_id,
  output logic              slot_last
);

  localparam logic [LEN_W-1:0] FULL_GAP = LEN_W'(BL - 1);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  logic [LEN_W-1:0]  gap_q, gap_d;
  sd_cmd_t           cmd_q, cmd_d;
  logic              addr_en;
  logic              a10_q;
  logic [BANK_W-1:0] ba_q;
  logic [COL_W-1:0]  col_q;
  logic              sv_q, sv_d;
  logic [ID_W-1:0]   sid_q;
  logic [LEN_W-1:0]  srem_q, srem_d;
  logic              accept;

  assign req_ready = (gap_q == '0);
  assign accept    = req_valid & req_ready;

  always_comb begin
    gap_d   = (gap_q != '0) ? gap_q - ONE : gap_q;
    cmd_d   = SD_NOP;
    addr_en = 1'b0;
    sv_d    = 1'b0;
    srem_d  = srem_q;
    if (sv_q && srem_q != '0) begin
      sv_d   = 1'b1;
      srem_d = srem_q - ONE;
    end
    if (accept) begin
      gap_d   = req_ap ? FULL_GAP : req_len;
      cmd_d   = SD_READ;
      addr_en = 1'b1;
      sv_d    = 1'b1;
      srem_d  = req_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      cmd_q  <= SD_NOP;
      sv_q   <= 1'b0;
      srem_q <= '0;
    end else begin
      gap_q  <= gap_d;
      cmd_q  <= cmd_d;
      sv_q   <= sv_d;
      srem_q <= srem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a10_q <= 1'b0;
      ba_q  <= '0;
      col_q <= '0;
      sid_q <= '0;
    end else if (addr_en) begin
      a10_q <= req_ap;
      ba_q  <= req_bank;
      col_q <= req_col;
      sid_q <= req_id;
    end
  end

  assign cmd       = cmd_q;
  assign cmd_a10   = a10_q;
  assign cmd_ba    = ba_q;
  assign cmd_col   = col_q;
  assign slot_v    = sv_q;
  assign slot_id   = sid_q;
  assign slot_last = sv_q & (srem_q == '0);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
  import sdram_rd_pkg::*;
#(
  parameter int ID_W = 4,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cl3,
  input  logic            slot_v,
  input  logic [ID_W-1:0] slot_id,
  input  logic            slot_last,
  input  logic [DQ_W-1:0] dq,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic [ID_W-1:0] rd_id,
  output logic            rd_last
);

  localparam int DEPTH = CL_LONG;

  logic [DEPTH-1:0] v_pipe;
  logic [DEPTH-1:0] l_pipe;
  logic [ID_W-1:0]  id_pipe [DEPTH];

  logic             tap_v, tap_l;
  logic [ID_W-1:0]  tap_id;

  logic             val_q, last_q;
  logic [DQ_W-1:0]  data_q;
  logic [ID_W-1:0]  id_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic            in_v, in_l;
    logic [ID_W-1:0] in_id;
    if (g == 0) begin : g_head
      assign in_v  = slot_v;
      assign in_l  = slot_last;
      assign in_id = slot_id;
    end else begin : g_body
      assign in_v  = v_pipe[g-1];
      assign in_l  = l_pipe[g-1];
      assign in_id = id_pipe[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_pipe[g] <= 1'b0;
        l_pipe[g] <= 1'b0;
      end else begin
        v_pipe[g] <= in_v;
        l_pipe[g] <= in_v & in_l;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    id_pipe[g] <= '0;
      else if (in_v) id_pipe[g] <= in_id;
    end
  end

  always_comb begin
    if (cfg_cl3) begin
      tap_v  = v_pipe[CL_LONG-1];
      tap_l  = l_pipe[CL_LONG-1];
      tap_id = id_pipe[CL_LONG-1];
    end else begin
      tap_v  = v_pipe[CL_SHORT-1];
      tap_l  = l_pipe[CL_SHORT-1];
      tap_id = id_pipe[CL_SHORT-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      val_q  <= tap_v;
      last_q <= tap_v & tap_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      id_q   <= '0;
    end else if (tap_v) begin
      data_q <= dq;
      id_q   <= tap_id;
    end
  end

  assign rd_valid = val_q;
  assign rd_data  = data_q;
  assign rd_id    = id_q;
  assign rd_last  = last_q;

endmodule

// File: rtl/sdram_rd_sched.sv
module sdram_rd_sched
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int BL     = 4,
  parameter int ID_W   = 4,
  parameter int DQ_W   = 16,
  localparam int LEN_W = $clog2(BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cl3,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ap,
  input  logic [ID_W-1:0]   req_id,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_a10,
  output logic [BANK_W-1:0] sd_ba,
  output logic [COL_W-1:0]  sd_col,
  input  logic [DQ_W-1:0]   sd_dq,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic [ID_W-1:0]   rd_id,
  output logic              rd_last
);

  logic            rst_meta_n, rst_sync_n;
  sd_cmd_t         cmd;
  logic            slot_v, slot_last;
  logic [ID_W-1:0] slot_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sdram_rd_issue #(
    .BANK_W(BANK_W), .COL_W(COL_W), .BL(BL), .ID_W(ID_W)
  ) u_issue (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_col   (req_col),
    .req_len   (req_len),
    .req_ap    (req_ap),
    .req_id    (req_id),
    .cmd       (cmd),
    .cmd_a10   (sd_a10),
    .cmd_ba    (sd_ba),
    .cmd_col   (sd_col),
    .slot_v    (slot_v),
    .slot_id   (slot_id),
    .slot_last (slot_last)
  );

  sdram_rd_capture #(
    .ID_W(ID_W), .DQ_W(DQ_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_cl3   (cfg_cl3),
    .slot_v    (slot_v),
    .slot_id   (slot_id),
    .slot_last (slot_last),
    .dq        (sd_dq),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_id     (rd_id),
    .rd_last   (rd_last)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdram_rd_sched_chk.sv
module sdram_rd_sched_chk #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cl3,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [COL_W-1:0]  req_col,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_ap,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_a10,
  input logic [BANK_W-1:0] sd_ba,
  input logic [COL_W-1:0]  sd_col,
  input logic              rd_valid,
  input logic              rd_last
);

  logic took, pins_read, pins_nop;
  assign took      = req_valid && req_ready;
  assign pins_read = !sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n;
  assign pins_nop  = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;

  // R2
  a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (pins_read && sd_ba == $past(req_bank) && sd_col == $past(req_col)
              && sd_a10 == $past(req_ap)));

  // R3
  a_r3_nop_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> pins_nop);

  // R4
  a_r4_lat_short: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_read && !cfg_cl3) |-> ##3 rd_valid);

  // R4
  a_r4_lat_long: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_read && cfg_cl3) |-> ##4 rd_valid);

  // R5
  a_r5_last_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R6
  a_r6_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (req_ap || req_len != '0)) |=> !req_ready);

  // R8
  a_r8_single_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !req_ap && req_len == '0) |=> req_ready);

endmodule

bind sdram_rd_sched sdram_rd_sched_chk #(
  .BANK_W(BANK_W), .COL_W(COL_W), .LEN_W(LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_cl3   (cfg_cl3),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bank  (req_bank),
  .req_col   (req_col),
  .req_len   (req_len),
  .req_ap    (req_ap),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_a10    (sd_a10),
  .sd_ba     (sd_ba),
  .sd_col    (sd_col),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last)
);

// File: tb/sdram_rd_sched_test.sv
`timescale 1ns/1ps
module sdram_rd_sched_test;

  localparam int BANK_W = 2, COL_W = 10, BL = 4, ID_W = 4, DQ_W = 16;
  localparam int LEN_W = $clog2(BL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cl3 = 1'b0;
  logic req_valid = 1'b0, req_ap = 1'b0;
  logic req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [ID_W-1:0]   req_id = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [BANK_W-1:0] sd_ba;
  logic [COL_W-1:0]  sd_col;
  logic [DQ_W-1:0]   sd_dq = '0;
  logic rd_valid, rd_last;
  logic [DQ_W-1:0] rd_data;
  logic [ID_W-1:0] rd_id;

  always #2.5 clk = ~clk;

  sdram_rd_sched uut (.*);

  int total = 0, bad = 0;
  bit done = 1'b0;

  // device model: data table indexed by the edge at which a word is valid
  logic [DQ_W-1:0] dtab [16];
  int mcyc = 0;
  function automatic logic [DQ_W-1:0] word_of(input int ba, input int col);
    return {ba[BANK_W-1:0], col[COL_W-1:0], 4'h5};
  endfunction
  always @(posedge clk) begin
    mcyc <= mcyc + 1;
    if (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n) begin
      for (int k = 0; k < BL; k++)
        dtab[(mcyc + (cfg_cl3 ? 3 : 2) + k) % 16] <= word_of(sd_ba, sd_col + k);
    end
  end
  always @(negedge clk) sd_dq <= dtab[mcyc % 16];

  // monitor
  int ncyc = 0, nout = 0, ncmd = 0;
  int o_data[64], o_id[64], o_last[64], o_cyc[64];
  int c_cyc[32], c_ba[32], c_col[32], c_a10[32];
  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    if (rd_valid && nout < 64) begin
      o_data[nout] <= rd_data; o_id[nout] <= rd_id; o_last[nout] <= rd_last;
      o_cyc[nout] <= ncyc; nout <= nout + 1;
    end
    if (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n && ncmd < 32) begin
      c_cyc[ncmd] <= ncyc; c_ba[ncmd] <= sd_ba; c_col[ncmd] <= sd_col;
      c_a10[ncmd] <= sd_a10; ncmd <= ncmd + 1;
    end
  end

  // request record
  int q_n = 0;
  int q_ba[32], q_col[32], q_len[32], q_ap[32], q_id[32];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    nout = 0; ncmd = 0; q_n = 0;
  endtask

  task automatic send(input int ba, input int col, input int len, input bit ap, input int id);
    req_bank = ba[BANK_W-1:0]; req_col = col[COL_W-1:0]; req_len = len[LEN_W-1:0];
    req_ap = ap; req_id = id[ID_W-1:0]; req_valid = 1'b1;
    q_ba[q_n] = ba; q_col[q_n] = col; q_len[q_n] = len; q_ap[q_n] = ap; q_id[q_n] = id;
    q_n++;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  // checks words, tags, latency, pins; gap_free demands a contiguous stream
  task automatic verify(input string tag, input bit gap_free);
    int w = 0;
    int cl = cfg_cl3 ? 3 : 2;
    chk(ncmd == q_n, "R2", {tag, " read count"}, ncmd, q_n);
    for (int i = 0; i < q_n; i++) begin
      chk(c_ba[i] == q_ba[i], "R2", {tag, " bank pins"}, c_ba[i], q_ba[i]);
      chk(c_col[i] == q_col[i], "R2", {tag, " column pins"}, c_col[i], q_col[i]);
      chk(c_a10[i] == q_ap[i], "R2", {tag, " a10 pin"}, c_a10[i], q_ap[i]);
      chk(o_cyc[w] - c_cyc[i] == cl + 1, "R4", {tag, " latency"},
          o_cyc[w] - c_cyc[i], cl + 1);
      for (int k = 0; k <= q_len[i]; k++) begin
        chk(o_data[w] == int'(word_of(q_ba[i], q_col[i] + k)), "R5", {tag, " word"},
            o_data[w], int'(word_of(q_ba[i], q_col[i] + k)));
        chk(o_id[w] == q_id[i], "R5", {tag, " id"}, o_id[w], q_id[i]);
        chk(o_last[w] == (k == q_len[i]), "R5", {tag, " last flag"}, o_last[w],
            k == q_len[i]);
        if (gap_free && w > 0)
          chk(o_cyc[w] == o_cyc[w-1] + 1, "R6", {tag, " no gap"}, o_cyc[w] - o_cyc[w-1], 1);
        w++;
      end
    end
    chk(nout == w, "R9", {tag, " word count"}, nout, w);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n, "R1", "nop in reset", 0, 1);
    chk(rd_valid == 1'b0 && rd_last == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n, "R3", "nop when idle", 0, 1);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "no output after reset", rd_valid, 0);
  endtask

  task automatic t_single();
    clear_logs();
    send(1, 12'h040, 3, 1'b0, 3);
    chk(req_ready == 1'b0, "R6", "ready low in window", req_ready, 0);
    settle();
    verify("single", 1'b1);
  endtask

  task automatic t_chain(input bit cl3, input string tag);
    cfg_cl3 = cl3;
    clear_logs();
    send(0, 12'h010, 1, 1'b0, 1);
    send(2, 12'h024, 3, 1'b0, 2);
    send(3, 12'h008, 0, 1'b0, 4);
    send(1, 12'h0f0, 2, 1'b0, 7);
    settle();
    verify(tag, 1'b1);
    for (int i = 1; i < ncmd; i++)
      chk(c_cyc[i] - c_cyc[i-1] == q_len[i-1] + 1, "R6", {tag, " read spacing"},
          c_cyc[i] - c_cyc[i-1], q_len[i-1] + 1);
  endtask

  task automatic t_singles();
    clear_logs();
    for (int i = 0; i < 5; i++) send(i % 4, 12'h100 + 4 * i, 0, 1'b0, 8 + i);
    settle();
    for (int i = 1; i < ncmd; i++)
      chk(c_cyc[i] - c_cyc[i-1] == 1, "R8", "read every cycle", c_cyc[i] - c_cyc[i-1], 1);
    verify("R8 singles", 1'b1);
  endtask

  task automatic t_autopre();
    clear_logs();
    send(2, 12'h080, 1, 1'b1, 5);
    send(3, 12'h0c0, 2, 1'b0, 6);
    settle();
    verify("autopre", 1'b0);
    chk(c_cyc[1] - c_cyc[0] == BL, "R7", "read after full burst", c_cyc[1] - c_cyc[0], BL);
    chk(o_cyc[2] - o_cyc[1] == BL - 1, "R7", "tail cycles idle", o_cyc[2] - o_cyc[1], BL - 1);
    chk(nout == 5, "R9", "burst tail not delivered", nout, 5);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_chain(1'b0, "R6 chain cl2");
    t_chain(1'b1, "R4 chain cl3");
    cfg_cl3 = 1'b0;
    t_singles();
    t_autopre();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule